// File: doc/BRIEF.md
# Programmable Sum-of-Products Array Core

This block is the logic core of a field-configurable two-level logic element. Twenty array inputs each feed the AND plane in both true and inverted form. That gives forty columns crossed by ninety product-term rows. Each row is a wide AND of the columns whose links are left in place. The rows are then gathered into eight OR sums, eight per-output enable terms, and one global reset term and one global preset term. The registers, pads and polarity muxes that would consume these signals are outside the block.

The configuration is a flat vector of 3600 link bits. It is loaded one bit per clock through a serial port qualified by a write enable. Once loaded, the array evaluates purely combinationally from the stored links, with no clock in the path from `arr_in` to the outputs. The rows are not shared out evenly. Outputs 2 to 5 each own twelve sum rows and the other four own eight. This lets heavier functions sit on the middle outputs.

Top module: `pal_array_core`

## Requirements
- R1: A synchronous active-low reset sets every link bit to 1 (intact). With all links intact, every product term is 0, so `sum_out`, `oe_out`, `preset_out` and `reset_out` are all 0.
- R2: While `cfg_we` is 1, each rising clock edge shifts `cfg_bit` into link index 3599 and moves every other link one index down. After 3600 writes, the first bit written sits at link index 0. While `cfg_we` is 0, the stored links do not change.
- R3: Link index r*40+2*i is the true link of input i in row r, and index r*40+2*i+1 is its complement link; a bit value of 1 means intact. True link alone intact requires `arr_in[i]`=1. Complement link alone intact requires `arr_in[i]`=0.
- R4: If both links of any input are intact in a row, that row is 0 whatever the inputs. This holds for sum, enable, preset and reset rows alike.
- R5: A row with every link removed (all 0) evaluates to 1.
- R6: Rows are laid out in blocks per output, in order 0 to 7. Each block starts with the output's enable row, followed by its sum rows: 12 for outputs 2 to 5 and 8 for the others. Row 88 is the reset term and row 89 the preset term.
- R7: `sum_out[k]` is the OR of output k's sum rows, including the last row of each block.
- R8: `oe_out[k]` equals output k's enable row, and `reset_out`/`preset_out` equal rows 88 and 89.
- R9: The outputs follow a change on `arr_in` within the same clock phase, without a clock edge.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the link store |
| rst_n | input | 1 | Synchronous active-low reset, restores all links intact |
| cfg_we | input | 1 | Shift enable for the configuration port |
| cfg_bit | input | 1 | Serial configuration data |
| arr_in | input | 20 | Array inputs |
| sum_out | output | 8 | OR sum per output |
| oe_out | output | 8 | Enable term per output |
| preset_out | output | 1 | Global preset term |
| reset_out | output | 1 | Global reset term |

## Verification
On every cycle, the assertions check how the link store moves: it fills with ones on reset, shifts exactly one position per write, and holds otherwise. In every row and on every evaluation, they also check that a fully intact link pair forces the term to 0 and that a fully removed row gives 1. The row layout, the uneven split of terms between outputs, and the OR gathering into each output can only be shown by the bench's scenarios. These load whole configurations and compare every output against a behavioural model while the inputs sweep.

// File: rtl/pal_cfg_pkg.sv
// Package: row layout arithmetic shared by the array core.
// Assumes the number of outputs is at most 32 (mask passed as int).
package pal_cfg_pkg;

    // Number of sum rows owned by output k.
    function automatic int sum_terms(input int k, input int big_mask,
                                     input int big_n, input int small_n);
        return big_mask[k] ? big_n : small_n;
    endfunction

    // First row (the enable row) of output k's block.
    function automatic int block_base(input int k, input int big_mask,
                                      input int big_n, input int small_n);
        int acc;
        acc = 0;
        for (int j = 0; j < k; j++)
            acc += 1 + sum_terms(j, big_mask, big_n, small_n);
        return acc;
    endfunction

    // Total rows: all output blocks plus the reset and preset rows.
    function automatic int total_rows(input int n_out, input int big_mask,
                                      input int big_n, input int small_n);
        return block_base(n_out, big_mask, big_n, small_n) + 2;
    endfunction

endpackage

// File: rtl/pal_fuse_store.sv
// Module: serial link store. Holds the whole configuration vector.
// Each write shifts one bit in at the top index. Reset restores
// every link to intact (1). Assumes rst_n is synchronous to clk.
module pal_fuse_store #(
    parameter int FUSES = 3600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_bit,
    output logic [FUSES-1:0] fuse_q
);

    // Purpose: reset to all-intact, otherwise shift on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fuse_q <= '1;
        else if (cfg_we)
            fuse_q <= {cfg_bit, fuse_q[FUSES-1:1]};
    end

    // R1
    reset_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (&fuse_q));

    // R2
    shift_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (fuse_q[FUSES-1] == $past(cfg_bit)));

    // R2
    shift_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (fuse_q[FUSES-2:0] == $past(fuse_q[FUSES-1:1])));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(fuse_q));

endmodule

// File: rtl/pal_product_row.sv
// Module: one AND-plane row. Each input has a true link (even index)
// and a complement link (odd index); 1 means intact. An intact link
// requires the matching literal to be true. Purely combinational.
module pal_product_row #(
    parameter int N_IN = 20
) (
    input  logic [N_IN-1:0]   arr_in,
    input  logic [2*N_IN-1:0] links,
    output logic              term
);

    logic [N_IN-1:0] t_lnk;
    logic [N_IN-1:0] c_lnk;

    // Split the interleaved link pairs into true and complement planes.
    for (genvar i = 0; i < N_IN; i++) begin : g_split
        assign t_lnk[i] = links[2*i];
        assign c_lnk[i] = links[2*i+1];
    end

    // Purpose: wide AND over every literal whose link is intact.
    always_comb begin
        term = &((~t_lnk | arr_in) & (~c_lnk | ~arr_in));
    end

    // Purpose: guard the two encoding corner cases of the row.
    always_comb begin
        if (!$isunknown({links, arr_in})) begin
            // R4
            if (|(t_lnk & c_lnk))
                dead_pair_chk: assert (term == 1'b0);
            // R5
            if (links == '0)
                all_free_chk: assert (term == 1'b1);
        end
    end

endmodule

// File: rtl/pal_term_or.sv
// Module: OR gather of one output's sum rows. Width set per output.
module pal_term_or #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] terms,
    output logic             hit
);

    // Purpose: any active product term drives the sum high.
    always_comb begin
        hit = |terms;
    end

endmodule

// File: rtl/pal_array_core.sv
// Module: top of the programmable sum-of-products core. It builds
// the rows from the link store, then gathers them into per-output
// enables, uneven OR sums, and the global reset and preset terms.
// Assumes the row layout of pal_cfg_pkg: a block per output
// (enable row first), then reset, then preset.
module pal_array_core #(
    parameter int              N_IN        = 20,
    parameter int              N_OUT       = 8,
    parameter int              BIG_TERMS   = 12,
    parameter int              SMALL_TERMS = 8,
    parameter logic [N_OUT-1:0] BIG_SEL    = 8'b0011_1100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_bit,
    input  logic [N_IN-1:0]  arr_in,
    output logic [N_OUT-1:0] sum_out,
    output logic [N_OUT-1:0] oe_out,
    output logic             preset_out,
    output logic             reset_out
);

    localparam int MASK    = 32'(BIG_SEL);
    localparam int ROWS    = pal_cfg_pkg::total_rows(N_OUT, MASK, BIG_TERMS, SMALL_TERMS);
    localparam int LINKS   = 2 * N_IN;
    localparam int FUSES   = ROWS * LINKS;
    localparam int RST_ROW = ROWS - 2;
    localparam int PRE_ROW = ROWS - 1;

    logic [FUSES-1:0] fuse_q;
    logic [ROWS-1:0]  row_val;

    pal_fuse_store #(.FUSES(FUSES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_bit (cfg_bit),
        .fuse_q  (fuse_q)
    );

    // One AND row per product term.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        pal_product_row #(.N_IN(N_IN)) u_row (
            .arr_in (arr_in),
            .links  (fuse_q[r*LINKS +: LINKS]),
            .term   (row_val[r])
        );
    end

    // Per-output block: enable row followed by a sized OR gather.
    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        localparam int BASE = pal_cfg_pkg::block_base(k, MASK, BIG_TERMS, SMALL_TERMS);
        localparam int NT   = pal_cfg_pkg::sum_terms(k, MASK, BIG_TERMS, SMALL_TERMS);

        pal_term_or #(.WIDTH(NT)) u_or (
            .terms (row_val[BASE+1 +: NT]),
            .hit   (sum_out[k])
        );

        assign oe_out[k] = row_val[BASE];
    end

    // Global control terms sit after the last output block.
    assign reset_out  = row_val[RST_ROW];
    assign preset_out = row_val[PRE_ROW];

endmodule

// File: tb/pal_array_core_tb.sv
`timescale 1ns/1ps
module pal_array_core_tb;

    localparam int NI = 20;
    localparam int NR = 90;
    localparam int FZ = NR * 2 * NI;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic        cfg_bit;
    logic [19:0] arr_in;
    logic [7:0]  sum_out, oe_out;
    logic        preset_out, reset_out;

    bit    m_lnk [FZ];   // reference copy of the link store
    bit    img   [FZ];   // configuration image to be loaded
    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    pal_array_core u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bit(cfg_bit),
        .arr_in(arr_in), .sum_out(sum_out), .oe_out(oe_out),
        .preset_out(preset_out), .reset_out(reset_out)
    );

    function automatic int nterms(int k);
        return (k >= 2 && k <= 5) ? 12 : 8;
    endfunction

    function automatic int base_of(int k);
        int b = 0;
        for (int j = 0; j < k; j++) b += 1 + nterms(j);
        return b;
    endfunction

    function automatic bit row_eval(int r);
        for (int i = 0; i < NI; i++) begin
            if (m_lnk[r*40 + 2*i]     && !arr_in[i]) return 1'b0;
            if (m_lnk[r*40 + 2*i + 1] &&  arr_in[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string what, input string req);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic compare_all();
        logic [7:0] es, eo;
        for (int k = 0; k < 8; k++) begin
            eo[k] = row_eval(base_of(k));
            es[k] = 1'b0;
            for (int t = 1; t <= nterms(k); t++) es[k] |= row_eval(base_of(k) + t);
        end
        chk(sum_out, es, "sum_out", cur_req);
        chk(oe_out, eo, "oe_out", cur_req);
        chk({7'd0, reset_out}, {7'd0, row_eval(88)}, "reset_out", cur_req);
        chk({7'd0, preset_out}, {7'd0, row_eval(89)}, "preset_out", cur_req);
    endtask

    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            for (int j = 0; j < FZ; j++) m_lnk[j] = 1'b1;
        end else if (cfg_we) begin
            for (int j = 0; j < FZ - 1; j++) m_lnk[j] = m_lnk[j+1];
            m_lnk[FZ-1] = cfg_bit;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic apply_in(input logic [19:0] v);
        arr_in = v;
        #0.5;
        cur_req = "R9";
        compare_all();
    endtask

    task automatic load_img();
        cur_req = "R2";
        for (int j = 0; j < FZ; j++) begin
            cfg_we  = 1'b1;
            cfg_bit = img[j];
            step();
        end
        cfg_we = 1'b0;
    endtask

    task automatic row_free(input int r);
        for (int j = 0; j < 40; j++) img[r*40 + j] = 1'b0;
    endtask

    task automatic lit(input int r, input int i, input bit hi);
        if (hi) img[r*40 + 2*i] = 1'b1;
        else    img[r*40 + 2*i + 1] = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [19:0] lf;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_bit = 1'b0; arr_in = '0;
        step(); step();
        // R1: reset state, everything intact, all outputs low
        chk(sum_out, 8'h00, "sum after reset", "R1");
        chk(oe_out, 8'h00, "oe after reset", "R1");
        chk({6'd0, preset_out, reset_out}, 8'h00, "ctl after reset", "R1");
        rst_n = 1'b1;
        step();

        // Configuration 1 built on the R3/R6 layout
        for (int j = 0; j < FZ; j++) img[j] = 1'b1;
        row_free(base_of(0) + 1); lit(base_of(0) + 1, 0, 1); lit(base_of(0) + 1, 1, 0);
        row_free(base_of(1) + 3); lit(base_of(1) + 3, 4, 1);
        row_free(base_of(2) + 12);
        row_free(base_of(3));     lit(base_of(3), 5, 1);
        row_free(base_of(7) + 8); lit(base_of(7) + 8, 7, 1);
        img[(base_of(7) + 8)*40 + 6] = 1'b1; img[(base_of(7) + 8)*40 + 7] = 1'b1;
        row_free(base_of(4));
        img[base_of(4)*40 + 38] = 1'b1; img[base_of(4)*40 + 39] = 1'b1;
        row_free(88); lit(88, 19, 1);
        row_free(89); lit(89, 10, 0); lit(89, 11, 1);
        load_img();

        // R3 R7: output 0 needs in0 high and in1 low; output 2 last row is free
        apply_in(20'h00001);
        chk(sum_out, 8'h05, "sum pattern A", "R3");
        chk(oe_out, 8'h00, "oe pattern A", "R8");
        // R6 R8: in4 feeds output 1, in5 enables output 3, reset/preset rows
        apply_in(20'h80830);
        chk(sum_out, 8'h06, "sum pattern B", "R6");
        chk(oe_out, 8'h08, "oe pattern B", "R8");
        chk({6'd0, preset_out, reset_out}, 8'h03, "ctl pattern B", "R8");
        // R4: intact pair kills output 7 row and output 4 enable
        apply_in(20'hFFFFF);
        chk({7'd0, sum_out[7]}, 8'h00, "dead sum row", "R4");
        chk({7'd0, oe_out[4]}, 8'h00, "dead enable row", "R4");
        chk({7'd0, sum_out[2]}, 8'h01, "last big row", "R7");

        // Sweep with the clock held off writes (R2 hold, R9 comb path)
        for (int b = 0; b < NI; b++) begin apply_in(20'd1 << b); cur_req = "R2"; step(); end
        for (int b = 0; b < NI; b++) begin apply_in(~(20'd1 << b)); cur_req = "R2"; step(); end
        lf = 20'h5A3C1;
        for (int n = 0; n < 40; n++) begin
            lf = {lf[18:0], lf[19] ^ lf[16]};
            apply_in(lf);
            cur_req = "R2";
            step();
        end

        // Configuration 2: every row free
        for (int j = 0; j < FZ; j++) img[j] = 1'b0;
        load_img();
        apply_in(20'h12345);
        chk(sum_out, 8'hFF, "all free sum", "R5");
        chk(oe_out, 8'hFF, "all free oe", "R5");
        chk({6'd0, preset_out, reset_out}, 8'h03, "all free ctl", "R5");

        // Reset again restores the intact state
        rst_n = 1'b0; cur_req = "R1"; step();
        rst_n = 1'b1; step();
        chk(sum_out, 8'h00, "sum after second reset", "R1");
        chk(oe_out, 8'h00, "oe after second reset", "R1");

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule